// File: doc/BRIEF.md
# Dual-Mode Synchronous FIFO with Programmable Flags

This block is a single-clock FIFO. By default it is 18 bits wide and 256 words deep. A timing mode is latched while reset is held, and it stays fixed until the next reset. In standard mode, a word moves to the data output only when the consumer requests a read. In fall-through mode, the block moves the oldest stored word into the output register by itself. The consumer reads the word that is already on the output, and the output register adds one word to the total capacity.

Two flag pins change meaning with the mode. In standard mode they are an active-low "not empty" indication and an active-low full indication. In fall-through mode they are an active-low output-ready and an active-high "cannot accept" indication. Three further active-low flags work in both modes: half-full, almost-empty and almost-full. Each one compares the total occupancy against a threshold that moves up by one word in fall-through mode. The almost-empty and almost-full thresholds come from two offset registers. Reset sets both offsets to DEPTH/8-1, and they can be reloaded through the data input.

Top module: `dual_mode_fifo`

## Requirements
- R1: While `rst` is high, the value on `mode_sel` is latched (0 = standard, 1 = fall-through), `dout` is cleared to 0 and the FIFO is emptied. The flags take their empty values: `half_n`=1, `aempty_n`=0, `afull_n`=1. In standard mode `flag_e`=0 and `flag_f`=1; in fall-through mode `flag_e`=1 and `flag_f`=0.
- R2: In standard mode, `rd_n` low at a rising edge with at least one word stored puts the oldest word on `dout` at that edge. If the FIFO is empty, a read changes neither `dout` nor any flag.
- R3: In fall-through mode, a word written into an empty FIFO appears on `dout` at the edge after its write edge, and `flag_e` falls at that same edge. `rd_n` low while `flag_e` is low consumes the word shown. The next word then follows on the same edge if one is stored, or one edge after it arrives.
- R4: In standard mode, `flag_e` is high exactly when at least one word is stored, and it changes at the edge of the write or read that causes the change. In fall-through mode, `flag_e` is low exactly when `dout` holds an unread word.
- R5: In standard mode, `flag_f` goes low when DEPTH words are stored. In fall-through mode, `flag_f` goes high when DEPTH+1 words are held. While either indication is active, writes are discarded, and the first accepted read releases it at that read's edge.
- R6: `half_n` is low while the occupancy is at least DEPTH/2+1 in standard mode, or at least DEPTH/2+2 in fall-through mode.
- R7: `aempty_n` is low while the occupancy is at most n in standard mode, or at most n+1 in fall-through mode. Here n is the empty offset.
- R8: `afull_n` is low while the occupancy is at least DEPTH-m in standard mode, or at least DEPTH+1-m in fall-through mode. Here m is the full offset.
- R9: Reset sets both offsets to DEPTH/8-1. When `ofs_ld_n` and `wr_n` are both low at an edge, the low log2(DEPTH) bits of `din` are written to an offset register instead of the FIFO. The registers are written in alternation: the empty offset first after reset, then the full offset, then the empty offset again. The flags use the new value from the following edge onward.
- R10: An accepted write and an accepted read in the same cycle, with the FIFO neither empty nor full, leave the occupancy and every flag unchanged.
- R11: Words leave the FIFO in the order in which they were written, in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both the write side and the read side |
| rst | input | 1 | Synchronous reset, active high |
| mode_sel | input | 1 | Timing mode, sampled during reset: 0 = standard, 1 = fall-through |
| wr_n | input | 1 | Write enable, active low |
| rd_n | input | 1 | Read enable, active low |
| ofs_ld_n | input | 1 | Offset-load select, active low; used together with `wr_n` |
| din | input | DATA_W | Write data; its low bits carry offset values during a load |
| dout | output | DATA_W | Registered read data |
| flag_e | output | 1 | Standard mode: not-empty, low when empty. Fall-through mode: output-ready, low when a word is shown |
| flag_f | output | 1 | Standard mode: full, active low. Fall-through mode: high when no more words fit |
| half_n | output | 1 | Half-full, active low |
| aempty_n | output | 1 | Almost-empty, active low |
| afull_n | output | 1 | Almost-full, active low |

## Verification
All flags are registered from the next-state occupancy. A flag caused by an accepted write, read or simultaneous pair is therefore valid at the same rising edge. The exception is fall-through `flag_e`, which reacts to a fill one edge later than the write. An offset load takes effect on flags from the edge after the load. The bench drives stimulus on the falling edge and samples on the next falling edge, which is half a cycle after the edge concerned. The fill and drain sweeps insert one idle edge after each operation, so the fall-through prefetch settles before the flags and `dout` are compared with an occupancy model. Separate directed checks sample right after the write edge and one edge later, to pin down the exact latency.

// File: rtl/dmf_pkg.sv
package dmf_pkg;

  typedef enum logic {
    MODE_STD  = 1'b0,
    MODE_FWFT = 1'b1
  } fifo_mode_e;

  typedef struct packed {
    logic ef_or;   // not-empty (std) / output-ready, low active (fwft)
    logic ff_ir;   // full, low active (std) / no-room, high active (fwft)
    logic hf;      // half full, low active
    logic ae;      // almost empty, low active
    logic af;      // almost full, low active
  } flag_t;

endpackage

// File: rtl/dmf_ram.sv
module dmf_ram #(
  parameter int DATA_W = 18,
  parameter int DEPTH  = 256,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // registered read port doubles as the FIFO output register
  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/dmf_ofs_regs.sv
module dmf_ofs_regs #(
  parameter int OFS_W   = 8,
  parameter int DEF_OFS = 31
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld,
  input  logic [OFS_W-1:0] val,
  output logic [OFS_W-1:0] e_ofs,
  output logic [OFS_W-1:0] f_ofs
);

  logic sel_full_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      e_ofs      <= OFS_W'(DEF_OFS);
      f_ofs      <= OFS_W'(DEF_OFS);
      sel_full_q <= 1'b0;
    end else if (ld) begin
      if (sel_full_q) f_ofs <= val;
      else            e_ofs <= val;
      sel_full_q <= ~sel_full_q;
    end
  end

endmodule

// File: rtl/dmf_flags.sv
module dmf_flags
  import dmf_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int OCC_W = 9,
  parameter int OFS_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_sel,
  input  logic             fwft,
  input  logic [OCC_W-1:0] cnt_nx,
  input  logic             ov_nx,
  input  logic [OFS_W-1:0] e_ofs,
  input  logic [OFS_W-1:0] f_ofs,
  output flag_t            flags_q
);

  localparam logic [OCC_W-1:0] FULL_CNT = OCC_W'(DEPTH);
  localparam logic [OCC_W-1:0] HALF_LIM = OCC_W'(DEPTH / 2 + 1);

  logic [OCC_W-1:0] shift, tot_nx, e_lim, h_lim, f_lim;
  flag_t            flags_d;

  always_comb begin
    shift  = OCC_W'(fwft);
    tot_nx = cnt_nx + OCC_W'(ov_nx);
    e_lim  = OCC_W'(e_ofs) + shift;
    h_lim  = HALF_LIM + shift;
    f_lim  = FULL_CNT - OCC_W'(f_ofs) + shift;
    flags_d.ef_or = fwft ? ~ov_nx : (cnt_nx != '0);
    flags_d.ff_ir = fwft ? (cnt_nx == FULL_CNT) : (cnt_nx != FULL_CNT);
    flags_d.hf    = ~(tot_nx >= h_lim);
    flags_d.ae    = ~(tot_nx <= e_lim);
    flags_d.af    = ~(tot_nx >= f_lim);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q.ef_or <= mode_sel;
      flags_q.ff_ir <= ~mode_sel;
      flags_q.hf    <= 1'b1;
      flags_q.ae    <= 1'b0;
      flags_q.af    <= 1'b1;
    end else begin
      flags_q <= flags_d;
    end
  end

  // R5
  full_implies_af_chk: assert property (@(posedge clk) disable iff (rst)
    (fwft ? flags_q.ff_ir : ~flags_q.ff_ir) |-> ~flags_q.af);

  // R4
  full_not_empty_chk: assert property (@(posedge clk) disable iff (rst)
    (~fwft && ~flags_q.ff_ir) |-> flags_q.ef_or);

endmodule

// File: rtl/dual_mode_fifo.sv
module dual_mode_fifo
  import dmf_pkg::*;
#(
  parameter int DATA_W = 18,
  parameter int DEPTH  = 256
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_sel,
  input  logic              wr_n,
  input  logic              rd_n,
  input  logic              ofs_ld_n,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              flag_e,
  output logic              flag_f,
  output logic              half_n,
  output logic              aempty_n,
  output logic              afull_n
);

  localparam int AW      = $clog2(DEPTH);
  localparam int OCC_W   = $clog2(DEPTH + 2);
  localparam int OFS_W   = AW;
  localparam int DEF_OFS = DEPTH / 8 - 1;
  localparam logic [OCC_W-1:0] FULL_CNT = OCC_W'(DEPTH);
  localparam logic [AW-1:0]    LAST_PTR = AW'(DEPTH - 1);

  fifo_mode_e       mode_q;
  logic             fwft;
  logic [OCC_W-1:0] cnt_q, cnt_nx;
  logic             ov_q, ov_nx;
  logic [AW-1:0]    wptr_q, rptr_q;
  logic             wr_go, fetch, ofs_wr;
  logic [OFS_W-1:0] e_ofs, f_ofs;
  flag_t            flags_q;

  assign fwft   = (mode_q == MODE_FWFT);
  assign ofs_wr = ~wr_n & ~ofs_ld_n;
  assign wr_go  = ~wr_n & ofs_ld_n & (cnt_q != FULL_CNT);

  always_comb begin
    if (fwft) begin
      fetch = (cnt_q != '0) & (~ov_q | ~rd_n);
      ov_nx = fetch | (ov_q & rd_n);
    end else begin
      fetch = ~rd_n & (cnt_q != '0);
      ov_nx = 1'b0;
    end
    cnt_nx = cnt_q + OCC_W'(wr_go) - OCC_W'(fetch);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= fifo_mode_e'(mode_sel);
      cnt_q  <= '0;
      ov_q   <= 1'b0;
      wptr_q <= '0;
      rptr_q <= '0;
    end else begin
      cnt_q <= cnt_nx;
      ov_q  <= ov_nx;
      if (wr_go) wptr_q <= (wptr_q == LAST_PTR) ? '0 : wptr_q + 1'b1;
      if (fetch) rptr_q <= (rptr_q == LAST_PTR) ? '0 : rptr_q + 1'b1;
    end
  end

  dmf_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ram (
    .clk   (clk),
    .rst   (rst),
    .we    (wr_go),
    .waddr (wptr_q),
    .wdata (din),
    .re    (fetch),
    .raddr (rptr_q),
    .rdata (dout)
  );

  dmf_ofs_regs #(.OFS_W(OFS_W), .DEF_OFS(DEF_OFS)) u_ofs (
    .clk   (clk),
    .rst   (rst),
    .ld    (ofs_wr),
    .val   (din[OFS_W-1:0]),
    .e_ofs (e_ofs),
    .f_ofs (f_ofs)
  );

  dmf_flags #(.DEPTH(DEPTH), .OCC_W(OCC_W), .OFS_W(OFS_W)) u_flags (
    .clk      (clk),
    .rst      (rst),
    .mode_sel (mode_sel),
    .fwft     (fwft),
    .cnt_nx   (cnt_nx),
    .ov_nx    (ov_nx),
    .e_ofs    (e_ofs),
    .f_ofs    (f_ofs),
    .flags_q  (flags_q)
  );

  assign flag_e   = flags_q.ef_or;
  assign flag_f   = flags_q.ff_ir;
  assign half_n   = flags_q.hf;
  assign aempty_n = flags_q.ae;
  assign afull_n  = flags_q.af;

  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= FULL_CNT);

  // R5
  full_write_blocked_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == FULL_CNT && rd_n) |=> (cnt_q == FULL_CNT));

  // R3
  fwft_fill_chk: assert property (@(posedge clk) disable iff (rst)
    (fwft && !ov_q && cnt_q != '0) |=> ov_q);

  // R2
  std_no_outreg_chk: assert property (@(posedge clk) disable iff (rst)
    !fwft |-> !ov_q);

  // R10
  rw_steady_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_go && fetch && (!fwft || ov_q)) |=> $stable(cnt_q));

endmodule

// File: tb/sim_dual_mode_fifo.sv
module sim_dual_mode_fifo;

  localparam int DW = 18;
  localparam int D  = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          mode_sel = 1'b0;
  logic          wr_n = 1'b1, rd_n = 1'b1, ofs_ld_n = 1'b1;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic          flag_e, flag_f, half_n, aempty_n, afull_n;

  int nchk = 0, nfail = 0;
  int occ, md, en, fm;
  logic [DW-1:0] q[$];
  logic [DW-1:0] last_out;

  always #5 clk = ~clk;

  dual_mode_fifo #(.DATA_W(DW), .DEPTH(D)) u0 (
    .clk(clk), .rst(rst), .mode_sel(mode_sel), .wr_n(wr_n), .rd_n(rd_n),
    .ofs_ld_n(ofs_ld_n), .din(din), .dout(dout), .flag_e(flag_e),
    .flag_f(flag_f), .half_n(half_n), .aempty_n(aempty_n), .afull_n(afull_n)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h (mode=%0d occ=%0d)", tag, act, exp, md, occ);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset(input int m);
    rst = 1'b1; mode_sel = m[0]; md = m;
    wr_n = 1'b1; rd_n = 1'b1; ofs_ld_n = 1'b1;
    cyc(); cyc();
    rst = 1'b0;
    mode_sel = ~m[0];  // must be ignored after reset
    occ = 0; q.delete(); en = D/8 - 1; fm = D/8 - 1; last_out = '0;
  endtask

  task automatic check_flags(input string ctx);
    chk({"R4 flag_e ", ctx}, flag_e, md ? (occ == 0) : (occ != 0));
    chk({"R5 flag_f ", ctx}, flag_f, md ? (occ == D + 1) : (occ != D));
    chk({"R6 half_n ", ctx}, half_n, !(occ >= D/2 + 1 + md));
    chk({"R7 aempty_n ", ctx}, aempty_n, !(occ <= en + md));
    chk({"R8 afull_n ", ctx}, afull_n, !(occ >= D - fm + md));
    if (md == 1 && occ > 0) chk({"R11 fwft head ", ctx}, dout, q[0]);
  endtask

  task automatic do_write(input logic [DW-1:0] v);
    din = v; wr_n = 1'b0;
    cyc();
    wr_n = 1'b1;
    if (occ < D + md) begin q.push_back(v); occ++; end
    cyc();
    check_flags("write");
  endtask

  task automatic do_read();
    rd_n = 1'b0;
    cyc();
    rd_n = 1'b1;
    if (md == 0) begin
      if (occ > 0) begin
        last_out = q.pop_front(); occ--;
        chk("R11 std read data", dout, last_out);
      end else begin
        chk("R2 empty read keeps dout", dout, last_out);
      end
    end else if (occ > 0) begin
      void'(q.pop_front()); occ--;
    end
    cyc();
    check_flags("read");
  endtask

  task automatic load_ofs(input int v);
    ofs_ld_n = 1'b0; wr_n = 1'b0; din = DW'(v);
    cyc();
    ofs_ld_n = 1'b1; wr_n = 1'b1;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int m = 0; m < 2; m++) begin
      // R1 reset state
      do_reset(m);
      chk("R1 dout after reset", dout, 0);
      chk("R1 flag_e reset", flag_e, m);
      chk("R1 flag_f reset", flag_f, 1 - m);
      chk("R1 half_n reset", half_n, 1);
      chk("R1 aempty_n reset", aempty_n, 0);
      chk("R1 afull_n reset", afull_n, 1);

      // R2 read while empty ignored
      do_read();

      // latency of the first word
      din = 18'h2A5A5; wr_n = 1'b0;
      cyc();
      wr_n = 1'b1;
      if (m == 0) begin
        chk("R4 std flag_e same edge", flag_e, 1);
        chk("R2 std dout waits for read", dout, 0);
        rd_n = 1'b0; cyc(); rd_n = 1'b1;
        chk("R2 std read data", dout, 18'h2A5A5);
        chk("R4 std flag_e after last read", flag_e, 0);
      end else begin
        chk("R3 fwft flag_e still high at write edge", flag_e, 1);
        cyc();
        chk("R3 fwft flag_e low next edge", flag_e, 0);
        chk("R3 fwft word shown", dout, 18'h2A5A5);
        rd_n = 1'b0; cyc(); rd_n = 1'b1;
        chk("R4 fwft flag_e high after last read", flag_e, 1);
      end

      // sweeps over offset configurations
      for (int cfg = 0; cfg < 4; cfg++) begin
        do_reset(m);
        if (cfg == 1) begin load_ofs(0); load_ofs(0); en = 0; fm = 0; end
        if (cfg == 2) begin load_ofs(5); load_ofs(3); en = 5; fm = 3; end
        if (cfg == 3) begin load_ofs(9); load_ofs(14); load_ofs(6); en = 6; fm = 14; end
        cyc();
        check_flags("R9 after offset load");
        for (int i = 0; i < D + m + 1; i++)
          do_write(DW'(i * 37 + cfg * 5 + m * 1000 + 1));
        for (int i = 0; i < D + m + 1; i++)
          do_read();
      end

      // R10 simultaneous write and read while partly full
      do_reset(m);
      for (int i = 0; i < 6; i++) do_write(DW'(i + 100));
      for (int i = 0; i < 5; i++) begin
        din = DW'(i + 200); wr_n = 1'b0; rd_n = 1'b0;
        cyc();
        wr_n = 1'b1; rd_n = 1'b1;
        q.push_back(DW'(i + 200));
        last_out = q.pop_front();
        if (m == 0) chk("R10 std data during r/w", dout, last_out);
        check_flags("R10 r/w same cycle");
      end
      cyc();
      check_flags("R10 settled");
      for (int i = 0; i < 7; i++) do_read();
    end
    finish_run();
  end

endmodule